// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block sits behind an Ethernet receive path and stores each incoming frame, delivered one byte at a time, into memory buffers of 128 bytes each. Which buffers it may use is decided by a circular list of two-word descriptors. The first word of each descriptor holds the buffer address and two flags: an ownership flag and a wrap flag. The second word carries frame-boundary flags and the frame length. A frame longer than one buffer spills into the buffers of the following descriptors. After a buffer is filled, the block writes its control word and then its address word, with the ownership flag set, so that software can pick the buffer up.

Software prepares the ring, points the block at the ring base and enables reception. It hands a buffer back by clearing its ownership flag. Three sticky status bits report the outcome of each frame: a frame was completed, the next buffer is still held by software, or a frame was lost. Memory is reached through one request/grant port. For a read, the data returns in the cycle after the grant.

Top module: `rx_ring_writer`

## Requirements
- R1: While reset is held, and in the cycle after it, the memory request is low and all status bits read 0.
- R2: Each buffer takes at most 128 bytes. Byte k of a buffer goes to byte lane k mod 4 (lane 0 = bits 7:0) of the word at buffer address + 4*(k div 4). A longer frame continues at byte 0 of the next descriptor's buffer.
- R3: The write-back of a descriptor's address word sets bit 0 (ownership) and keeps bits 31:2 (buffer address) and bit 1 (wrap) as fetched.
- R4: Descriptors are 8 bytes apart, with the address word at offset 0 and the control word at offset 4. After a descriptor whose wrap bit (bit 1) is set, the next descriptor used is the one at `ring_base`.
- R5: Control word bit 14 marks the first buffer of a frame and bit 15 marks its last buffer. All other buffers have both bits clear.
- R6: Control word bits 11:0 hold the total frame length in bytes in the last buffer of a frame, and 0 in every other buffer.
- R7: A buffer's address word is written only after its data words and its control word are in memory.
- R8: Fetching a descriptor whose ownership bit is set raises status bit 1 (buffer unavailable). A frame that cannot be stored raises status bit 2 (overrun). A frame that arrives while no buffer is free is consumed and produces no memory write.
- R9: If buffers run out partway through a frame, the buffers already filled are handed over without an end-of-frame mark. The rest of the frame is discarded, and no descriptor is written until a buffer is returned.
- R10: Status bit 0 rises when the last buffer of a frame is handed over. Writing a one to a bit of `sts_clr` clears that status bit. A set in the same cycle wins over the clear.
- R11: Re-enabling reception (`rx_enable` going 0 then 1) restarts the descriptor walk at `ring_base`.
- R12: A memory request keeps its address, direction and write data unchanged until it is granted.
- R13: No input byte is accepted while a memory request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Reception enable; a rising edge reloads the ring pointer |
| ring_base | input | 32 | Byte address of the first descriptor |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ready | output | 1 | Block accepts the byte this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data, valid the cycle after a read is granted |
| sts | output | 3 | Sticky status: bit 0 complete, bit 1 buffer unavailable, bit 2 overrun |
| sts_clr | input | 3 | Write-one-to-clear strobes for `sts` |

## Verification
Most internal faults show up at the next descriptor write-back, at most one buffer (about 32 word writes) after the fault occurs. A wrong ring pointer writes a descriptor slot out of order. A wrong byte counter misplaces data, or marks the buffer with the wrong length or boundary flags. A stale wrap bit sends the walk past the end of the ring instead of back to the base. A wrong ownership decision shows up differently: writes to a buffer that software still holds, or a missing overrun bit. Those can be seen only when the next frame arrives, so the bench sends frames into an exhausted ring on purpose and then checks the status bits together with the absence of writes.

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int ADDR_W    = 32,
  parameter int BUF_BYTES = 128,
  parameter int LEN_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_enable,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_gnt,
  input  logic [31:0]       mem_rdata,
  output logic [2:0]        sts,
  input  logic [2:0]        sts_clr
);
  localparam int CNT_W = $clog2(BUF_BYTES) + 1;

  typedef enum logic [3:0] {
    S_OFF, S_FETCH, S_FWAIT, S_FILL, S_WDATA, S_WCTRL, S_WADDR, S_DROP, S_BLOCK
  } state_t;

  state_t             state;
  logic [ADDR_W-1:0]  ptr, buf_base;
  logic               wrap_r, sof_r, frame_on, last_r;
  logic [CNT_W-1:0]   bcnt;
  logic [LEN_W-1:0]   flen;
  logic [31:0]        word;
  logic [31:0]        ctrl_w;
  logic [CNT_W-1:0]   bm1;
  logic               accept, done_set, nobuf_set, ovr_set;

  assign in_ready  = (state == S_OFF) || (state == S_FILL) || (state == S_DROP);
  assign accept    = in_valid && in_ready;
  assign mem_req   = (state == S_FETCH) || (state == S_WDATA) ||
                     (state == S_WCTRL) || (state == S_WADDR);
  assign mem_we    = (state != S_FETCH);
  assign bm1       = bcnt - CNT_W'(1);
  assign done_set  = (state == S_WADDR) && mem_gnt && last_r;
  assign nobuf_set = (state == S_FWAIT) && mem_rdata[0];
  assign ovr_set   = nobuf_set && frame_on;

  always_comb begin
    ctrl_w = '0;
    ctrl_w[15] = last_r;
    ctrl_w[14] = sof_r;
    if (last_r) ctrl_w[LEN_W-1:0] = flen;
  end

  always_comb begin
    mem_addr  = ptr;
    mem_wdata = {buf_base[ADDR_W-1:2], wrap_r, 1'b1};
    case (state)
      S_WDATA: begin
        mem_addr  = buf_base + ADDR_W'({bm1[CNT_W-1:2], 2'b00});
        mem_wdata = word;
      end
      S_WCTRL: begin
        mem_addr  = ptr + ADDR_W'(4);
        mem_wdata = ctrl_w;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts <= '0;
    else        sts <= (sts & ~sts_clr) | {ovr_set, nobuf_set, done_set};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_OFF;
      ptr      <= '0;
      buf_base <= '0;
      wrap_r   <= 1'b0;
      sof_r    <= 1'b1;
      frame_on <= 1'b0;
      last_r   <= 1'b0;
      bcnt     <= '0;
      flen     <= '0;
      word     <= '0;
    end else if (!rx_enable) begin
      state <= S_OFF;
    end else begin
      case (state)
        S_OFF: begin
          ptr      <= ring_base;
          sof_r    <= 1'b1;
          frame_on <= 1'b0;
          last_r   <= 1'b0;
          flen     <= '0;
          state    <= S_FETCH;
        end
        S_FETCH: if (mem_gnt) state <= S_FWAIT;
        S_FWAIT: begin
          if (mem_rdata[0]) begin
            state <= frame_on ? S_DROP : S_BLOCK;
          end else begin
            buf_base <= {mem_rdata[ADDR_W-1:2], 2'b00};
            wrap_r   <= mem_rdata[1];
            bcnt     <= '0;
            word     <= '0;
            state    <= S_FILL;
          end
        end
        S_FILL: if (accept) begin
          word[8*bcnt[1:0] +: 8] <= in_data;
          bcnt     <= bcnt + CNT_W'(1);
          flen     <= flen + LEN_W'(1);
          frame_on <= 1'b1;
          last_r   <= in_last;
          if (in_last || bcnt[1:0] == 2'd3) state <= S_WDATA;
        end
        S_WDATA: if (mem_gnt) begin
          word  <= '0;
          state <= (last_r || bcnt == CNT_W'(BUF_BYTES)) ? S_WCTRL : S_FILL;
        end
        S_WCTRL: if (mem_gnt) begin
          sof_r <= 1'b0;
          state <= S_WADDR;
        end
        S_WADDR: if (mem_gnt) begin
          ptr <= wrap_r ? ring_base : ptr + ADDR_W'(8);
          if (last_r) begin
            frame_on <= 1'b0;
            last_r   <= 1'b0;
            flen     <= '0;
            sof_r    <= 1'b1;
          end
          state <= S_FETCH;
        end
        S_DROP: if (accept && in_last) begin
          frame_on <= 1'b0;
          flen     <= '0;
          sof_r    <= 1'b1;
          state    <= S_BLOCK;
        end
        S_BLOCK: if (in_valid) begin
          frame_on <= 1'b1;
          state    <= S_FETCH;
        end
        default: state <= S_OFF;
      endcase
    end
  end
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_enable,
  input logic              in_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_gnt,
  input logic [2:0]        sts,
  input logic [2:0]        sts_clr
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!mem_req && sts == 3'b000));

  assert_req_held_R12: assert property (@(posedge clk) disable iff (!rst_n || !rx_enable)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_no_accept_during_req_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && mem_req));

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sts[0] && !sts_clr[0] |=> sts[0]);

  assert_done_after_handover_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[0]) |-> $past(mem_req && mem_we && mem_gnt && mem_wdata[0]));

  assert_overrun_with_nobuf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[2]) |-> sts[1]);

  assert_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);
endmodule

bind rx_ring_writer rx_ring_writer_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/rx_ring_writer_bench.sv
module rx_ring_writer_bench;
  localparam int RB   = 32'h20;
  localparam int BUFB = 32'h100;
  localparam int ND   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_enable = 1'b0;
  logic [31:0] ring_base = RB;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        in_ready;
  logic        mem_req, mem_we, mem_gnt;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [2:0]  sts;
  logic [2:0]  sts_clr = '0;

  logic [31:0] mem [0:255];
  logic [7:0]  lfsr = 8'h5a;

  int n_chk = 0, n_fail = 0, exp_idx = 0;
  bit finished = 0;
  bit q_sof[$], q_eof[$];
  int q_len[$], q_n[$];
  logic [7:0] q_byte[$];

  always #4 clk = ~clk;

  rx_ring_writer u_rx_ring_writer (.*);

  assign mem_gnt = mem_req && (lfsr[0] | lfsr[3]);

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (mem_req && mem_gnt) begin
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[9:2]];
    end
  end

  function automatic logic [7:0] getb(int a);
    return mem[a[9:2]][8*a[1:0] +: 8];
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_req && mem_we && mem_gnt && mem_addr >= RB && mem_addr < RB + 8*ND
        && mem_addr[2] == 1'b0) begin
      int idx, n, len, bad;
      bit sof, eof;
      logic [31:0] ctrl;
      idx = (mem_addr - RB) >> 3;
      if (q_n.size() == 0) begin
        chk(0, "R8/R9 unexpected handover", mem_addr, 0);
      end else begin
        sof = q_sof.pop_front(); eof = q_eof.pop_front();
        len = q_len.pop_front(); n = q_n.pop_front();
        chk(idx == exp_idx, "R4/R11 descriptor order", idx, exp_idx);
        exp_idx = (exp_idx + 1) % ND;
        ctrl = mem[(mem_addr + 4) >> 2];
        chk(ctrl[15] == eof && ctrl[14] == sof, "R5 boundary flags", ctrl[15:14], {eof, sof});
        chk(ctrl[11:0] == (eof ? len : 0), "R6 length field", ctrl[11:0], eof ? len : 0);
        chk(mem_wdata == ((BUFB + idx*128) | (idx == ND-1 ? 2 : 0) | 1), "R3 address word",
            mem_wdata, (BUFB + idx*128) | (idx == ND-1 ? 2 : 0) | 1);
        bad = 0;
        for (int k = 0; k < n; k++) begin
          logic [7:0] e;
          e = q_byte.pop_front();
          if (getb(BUFB + idx*128 + k) != e) bad++;
        end
        chk(bad == 0, "R2/R7 buffer data before handover", bad, 0);
      end
    end
  end

  task automatic init_ring();
    for (int i = 0; i < ND; i++) begin
      mem[(RB + 8*i) >> 2]     = (BUFB + i*128) | (i == ND-1 ? 2 : 0);
      mem[(RB + 8*i + 4) >> 2] = 32'h0;
    end
  endtask

  task automatic release_all();
    @(negedge clk);
    for (int i = 0; i < ND; i++) mem[(RB + 8*i) >> 2][0] = 1'b0;
  endtask

  task automatic clear_sts();
    @(negedge clk); sts_clr = 3'b111;
    @(negedge clk); sts_clr = 3'b000;
  endtask

  task automatic reenable();
    @(negedge clk); rx_enable = 0;
    repeat (3) @(negedge clk);
    rx_enable = 1; exp_idx = 0;
  endtask

  task automatic send_frame(int len, int avail);
    int rem = len, pos = 0;
    bit first = 1;
    while (rem > 0 && avail > 0) begin
      int n = rem > 128 ? 128 : rem;
      q_sof.push_back(first); q_eof.push_back(rem <= 128);
      q_len.push_back(len); q_n.push_back(n);
      for (int k = 0; k < n; k++) q_byte.push_back(8'((len + 7*(pos + k)) & 8'hff));
      pos += n; rem -= n; avail--; first = 0;
    end
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = 8'((len + 7*i) & 8'hff); in_last = (i == len - 1);
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk); in_valid = 0; in_last = 0;
    while (q_n.size() != 0) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  initial begin
    init_ring();
    repeat (3) @(negedge clk);
    chk(!mem_req && sts == 0, "R1 reset state", {mem_req, sts}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!mem_req && sts == 0, "R1 after reset", {mem_req, sts}, 0);
    rx_enable = 1; exp_idx = 0;

    send_frame(10, 4);
    chk(sts == 3'b001, "R10 complete flag", sts, 1);
    clear_sts();
    chk(sts == 3'b000, "R10 write-one clear", sts, 0);
    send_frame(128, 4);
    release_all();
    send_frame(300, 4);
    chk(sts == 3'b001, "R2 multi-buffer frame status", sts, 1);

    release_all(); reenable(); clear_sts();
    send_frame(600, 4);
    chk(sts == 3'b110, "R9 exhaustion mid-frame", sts, 6);
    clear_sts();
    send_frame(20, 0);
    chk(sts == 3'b110, "R8 frame with no free buffer", sts, 6);

    release_all(); clear_sts();
    send_frame(5, 4);
    chk(sts == 3'b001, "R8 recovery after release", sts, 1);
    release_all(); reenable(); clear_sts();
    send_frame(40, 4);
    chk(exp_idx == 1, "R11 restart at ring base", exp_idx, 1);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule